// File: doc/BRIEF.md
# Compressed Line Offset Calculator

This block locates one 64-byte cache line inside a compressed 4KB page. A request carries the page's descriptor (a 2-bit stored-size code for every one of the 64 lines, a flag telling whether the page is kept compressed, and a flag telling whether the whole page is zero) together with the 6-bit index of the wanted line. The block answers with the line's byte offset within the page, its stored size in bytes, and a zero-line flag meaning no memory access is needed. It also returns a split flag, raised when the line's bytes straddle a 64-byte boundary, and the number of 64-byte bursts the access takes.

For a compressed page the offset is a prefix sum over the size codes of all lines below the index, computed in 8-byte units so that each addend is 0, 1, 4 or 8. For an uncompressed page the offset is simply the index times 64. The answer is registered, so it appears one cycle after the request is accepted, whatever the index.

Requests and responses use a valid/ready handshake around a one-entry result slot controlled by a two-state machine. State ST_EMPTY means no result is held, and state ST_FULL means a result is held. The transitions are ACCEPT (ST_EMPTY to ST_FULL on an accepted request), DRAIN (ST_FULL to ST_EMPTY when the result is taken and no new request enters), REPLACE (ST_FULL to ST_FULL when the result is taken and a new request is accepted on the same edge) and HOLD (ST_FULL to ST_FULL while the consumer stalls).

Top module: `cline_locator`

## Requirements
- R1: Line j's code sits at bits [2j+1:2j] of `req_codes`; in a compressed page code 00 stores 0 bytes, 01 stores 8, 10 stores 32 and 11 stores 64, reported on `rsp_size`.
- R2: In a compressed, non-zero page the offset is 8 times the sum of the unit counts (0, 1, 4, 8) of all lines with an index below `req_index`; index 0 gives offset 0.
- R3: When the compressed flag is 0 and the zero flag is 0, the offset is index×64, the size is 64, the bursts are 1 and the split flag is 0, whatever the codes hold.
- R4: When the zero-page flag is 1, the response has zero-line 1, size 0, offset 0, bursts 0 and split 0, whatever the codes and the compressed flag hold.
- R5: A line of stored size 0 in a compressed page reports zero-line 1 and bursts 0.
- R6: A line whose first and last bytes lie in different 64-byte blocks reports split 1 and bursts 2.
- R7: A non-zero line held within one 64-byte block reports split 0 and bursts 1.
- R8: A request accepted on an edge yields `rsp_valid` high after that edge; when a response is taken with no new request accepted, `rsp_valid` is low after the edge.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the response fields stay unchanged and `req_ready` is low.
- R10: While reset is asserted and right after it, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_codes | input | 128 | Size codes, 2 bits per line, line 0 in the low bits |
| req_compressed | input | 1 | Page is stored compressed |
| req_zero_page | input | 1 | Page is all zeros |
| req_index | input | 6 | Index of the wanted line |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_offset | output | 12 | Byte offset of the line in the page |
| rsp_size | output | 7 | Stored size of the line in bytes |
| rsp_zero_line | output | 1 | Line needs no memory access |
| rsp_split | output | 1 | Line crosses a 64-byte boundary |
| rsp_bursts | output | 2 | Number of 64-byte bursts (0, 1 or 2) |

## Verification
A slot machine stuck in ST_FULL shows as `req_ready` held low with a stalled consumer, and one stuck in ST_EMPTY shows as a missing `rsp_valid` on the cycle after an accepted request. Both are visible within one cycle. A wrong lane mask or a wrong decode in the prefix sum only shows on requests whose index lies above the faulty lane with a non-zero code there, so random pages with random indices are mixed with full-page sums at index 63. Split detection errors appear only at offsets near a 64-byte block edge, which the directed pages place on purpose.

// File: rtl/cline_pkg.sv
package cline_pkg;

    localparam int UNIT_BYTES = 8;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } slot_state_t;

    // Stored size of a line in 8-byte units for each 2-bit code.
    function automatic logic [3:0] code_to_units(input logic [1:0] code);
        logic [3:0] u;
        unique case (code)
            2'b00:   u = 4'd0;
            2'b01:   u = 4'd1;
            2'b10:   u = 4'd4;
            default: u = 4'd8;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/cline_size_decode.sv
module cline_size_decode #(
    parameter int LINES  = 64,
    parameter int CODE_W = 2,
    parameter int UNIT_W = 4
) (
    input  logic [LINES*CODE_W-1:0] codes,
    output logic [LINES*UNIT_W-1:0] units
);

    for (genvar g = 0; g < LINES; g++) begin : g_lane
        assign units[g*UNIT_W +: UNIT_W] =
            UNIT_W'(cline_pkg::code_to_units(codes[g*CODE_W +: CODE_W]));
    end

endmodule

// File: rtl/cline_prefix_sum.sv
module cline_prefix_sum #(
    parameter int LINES  = 64,
    parameter int UNIT_W = 4,
    parameter int IDX_W  = 6,
    parameter int SUM_W  = 9
) (
    input  logic [LINES*UNIT_W-1:0] units,
    input  logic [IDX_W-1:0]        idx,
    output logic [SUM_W-1:0]        sum
);

    logic [UNIT_W-1:0] masked [LINES];

    // Only lanes strictly below the requested index contribute.
    for (genvar g = 0; g < LINES; g++) begin : g_mask
        assign masked[g] = (IDX_W'(g) < idx) ? units[g*UNIT_W +: UNIT_W] : '0;
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < LINES; k++) begin
            sum = sum + SUM_W'(masked[k]);
        end
    end

endmodule

// File: rtl/cline_ctrl.sv
module cline_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic rsp_ready,
    output logic req_ready,
    output logic rsp_valid,
    output logic load_en
);

    import cline_pkg::*;

    slot_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        req_ready = 1'b1;
        rsp_valid = 1'b0;
        state_d   = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                req_ready = 1'b1;
                rsp_valid = 1'b0;
                if (req_valid) state_d = ST_FULL;           // ACCEPT
            end
            ST_FULL: begin
                req_ready = rsp_ready;
                rsp_valid = 1'b1;
                if (rsp_ready && !req_valid) state_d = ST_EMPTY; // DRAIN
                else                         state_d = ST_FULL;  // REPLACE / HOLD
            end
            default: state_d = ST_EMPTY;
        endcase
        load_en = req_valid && req_ready;
    end

endmodule

// File: rtl/cline_locator.sv
module cline_locator #(
    parameter int LINES  = 64,
    parameter int UNIT_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [LINES*2-1:0]           req_codes,
    input  logic                         req_compressed,
    input  logic                         req_zero_page,
    input  logic [$clog2(LINES)-1:0]     req_index,
    output logic                         rsp_valid,
    input  logic                         rsp_ready,
    output logic [$clog2(LINES*8)+2:0]   rsp_offset,
    output logic [6:0]                   rsp_size,
    output logic                         rsp_zero_line,
    output logic                         rsp_split,
    output logic [1:0]                   rsp_bursts
);

    localparam int CODE_W = 2;
    localparam int IDX_W  = $clog2(LINES);
    localparam int SUM_W  = $clog2(LINES*8);
    localparam int OFF_W  = SUM_W + 3;
    localparam int SIZE_W = 7;

    logic [LINES*UNIT_W-1:0] units;
    logic [SUM_W-1:0]        sum;
    logic [UNIT_W-1:0]       sel_units;
    logic [SUM_W:0]          last_unit;
    logic                    load_en;

    logic [OFF_W-1:0]  off_d;
    logic [SIZE_W-1:0] size_d;
    logic              zl_d, split_d;
    logic [1:0]        bursts_d;

    cline_size_decode #(.LINES(LINES), .CODE_W(CODE_W), .UNIT_W(UNIT_W)) dec_i (
        .codes (req_codes),
        .units (units)
    );

    cline_prefix_sum #(.LINES(LINES), .UNIT_W(UNIT_W), .IDX_W(IDX_W), .SUM_W(SUM_W)) sum_i (
        .units (units),
        .idx   (req_index),
        .sum   (sum)
    );

    cline_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .rsp_ready (rsp_ready),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .load_en   (load_en)
    );

    assign sel_units = units[req_index*UNIT_W +: UNIT_W];
    assign last_unit = {1'b0, sum} + (SUM_W+1)'(sel_units) - (SUM_W+1)'(1);

    always_comb begin
        if (req_zero_page) begin
            off_d    = '0;
            size_d   = '0;
            zl_d     = 1'b1;
            split_d  = 1'b0;
            bursts_d = 2'd0;
        end else if (!req_compressed) begin
            off_d    = OFF_W'(req_index) << 6;
            size_d   = SIZE_W'(64);
            zl_d     = 1'b0;
            split_d  = 1'b0;
            bursts_d = 2'd1;
        end else begin
            off_d    = OFF_W'(sum) << 3;
            size_d   = SIZE_W'(sel_units) << 3;
            zl_d     = (sel_units == '0);
            split_d  = !zl_d && (last_unit[SUM_W:3] != {1'b0, sum[SUM_W-1:3]});
            bursts_d = zl_d ? 2'd0 : (split_d ? 2'd2 : 2'd1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_offset    <= '0;
            rsp_size      <= '0;
            rsp_zero_line <= 1'b0;
            rsp_split     <= 1'b0;
            rsp_bursts    <= 2'd0;
        end else if (load_en) begin
            rsp_offset    <= off_d;
            rsp_size      <= size_d;
            rsp_zero_line <= zl_d;
            rsp_split     <= split_d;
            rsp_bursts    <= bursts_d;
        end
    end

endmodule

// File: rtl/cline_locator_chk.sv
module cline_locator_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [11:0] rsp_offset,
    input logic [6:0]  rsp_size,
    input logic        rsp_zero_line,
    input logic        rsp_split,
    input logic [1:0]  rsp_bursts
);

    AST_RESP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid); // R8

    AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready && !req_valid) |=> !rsp_valid); // R8

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_offset) && $stable(rsp_size)
            && $stable(rsp_zero_line) && $stable(rsp_split) && $stable(rsp_bursts))); // R9

    AST_STALL_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |-> !req_ready); // R9

    AST_ZERO_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_zero_line) |-> (rsp_bursts == 2'd0 && rsp_size == 7'd0 && !rsp_split)); // R5

    AST_SPLIT_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_split) |-> (rsp_bursts == 2'd2)); // R6

    AST_ALIGNED_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_split && !rsp_zero_line) |-> (rsp_bursts == 2'd1)); // R7

endmodule

bind cline_locator cline_locator_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_offset    (rsp_offset),
    .rsp_size      (rsp_size),
    .rsp_zero_line (rsp_zero_line),
    .rsp_split     (rsp_split),
    .rsp_bursts    (rsp_bursts)
);

// File: tb/cline_locator_tb_top.sv
module cline_locator_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [127:0] req_codes = '0;
    logic         req_compressed = 1'b0;
    logic         req_zero_page = 1'b0;
    logic [5:0]   req_index = '0;
    logic         rsp_valid;
    logic         rsp_ready = 1'b1;
    logic [11:0]  rsp_offset;
    logic [6:0]   rsp_size;
    logic         rsp_zero_line;
    logic         rsp_split;
    logic [1:0]   rsp_bursts;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    cline_locator dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_codes(req_codes), .req_compressed(req_compressed), .req_zero_page(req_zero_page),
        .req_index(req_index), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_offset(rsp_offset), .rsp_size(rsp_size), .rsp_zero_line(rsp_zero_line),
        .rsp_split(rsp_split), .rsp_bursts(rsp_bursts)
    );

    function automatic int code_bytes(input logic [1:0] c);
        case (c)
            2'b00: return 0;
            2'b01: return 8;
            2'b10: return 32;
            default: return 64;
        endcase
    endfunction

    // Expected response packed as {offset, size, zero_line, split, bursts}.
    function automatic logic [22:0] expect_rsp(input logic [127:0] codes, input bit comp,
                                               input bit zp, input int idx);
        int off, sz, bu;
        bit zl, sp;
        if (zp) begin
            off = 0; sz = 0; zl = 1; sp = 0; bu = 0;
        end else if (!comp) begin
            off = idx * 64; sz = 64; zl = 0; sp = 0; bu = 1;
        end else begin
            off = 0;
            for (int j = 0; j < idx; j++) off += code_bytes(codes[2*j +: 2]);
            sz = code_bytes(codes[2*idx +: 2]);
            zl = (sz == 0);
            sp = !zl && ((off / 64) != ((off + sz - 1) / 64));
            bu = zl ? 0 : (sp ? 2 : 1);
        end
        return {off[11:0], sz[6:0], zl, sp, bu[1:0]};
    endfunction

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_rsp(input string req, input logic [22:0] exp);
        check_eq({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        check_eq({req, " response"}, 32'({rsp_offset, rsp_size, rsp_zero_line, rsp_split, rsp_bursts}),
                 32'(exp));
    endtask

    // Drive at negedge, accept at next posedge, check at the following negedge.
    task automatic send(input string req, input logic [127:0] codes, input bit comp,
                        input bit zp, input int idx);
        req_codes = codes; req_compressed = comp; req_zero_page = zp;
        req_index = 6'(idx); req_valid = 1'b1; rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp(req, expect_rsp(codes, comp, zp, idx));
        @(negedge clk);
    endtask

    task automatic finish_up();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            finish_up();
        end
    end

    initial begin
        logic [127:0] pg;
        logic [22:0]  held;
        void'($urandom(32'd1234));

        // R10: reset state
        repeat (3) @(negedge clk);
        check_eq("R10 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R10 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check_eq("R10 req_ready after reset", 32'(req_ready), 32'd1);

        // R1 R2: all 64-byte lines, last index sums 63 lines
        send("R2 all max idx63", {64{2'b11}}, 1, 0, 63);
        send("R2 idx0", {64{2'b11}}, 1, 0, 0);
        // R1 R7: 8-byte lines, index 7 ends at byte 63
        send("R7 8B idx7", {64{2'b01}}, 1, 0, 7);
        send("R1 8B idx8", {64{2'b01}}, 1, 0, 8);
        // R6: 32 then 64 -> line1 at 32, crosses
        pg = '0; pg[1:0] = 2'b10; pg[3:2] = 2'b11;
        send("R6 32+64 split", pg, 1, 0, 1);
        // R6: 32,8,32 -> line2 at 40 ends at 71
        pg = '0; pg[1:0] = 2'b10; pg[3:2] = 2'b01; pg[5:4] = 2'b10;
        send("R6 offset40 split", pg, 1, 0, 2);
        // R5: zero-size line
        send("R5 zero line", pg, 1, 0, 3);
        // R3: uncompressed ignores codes
        send("R3 uncompressed", {64{2'b01}}, 0, 0, 45);
        send("R3 uncompressed idx63", '0, 0, 0, 63);
        // R4: zero page beats compressed flag and codes
        send("R4 zero page comp", {64{2'b11}}, 1, 1, 50);
        send("R4 zero page uncomp", {64{2'b10}}, 0, 1, 5);

        // R9: stall holds response, blocks new requests
        pg = {64{2'b10}};
        req_codes = pg; req_compressed = 1; req_zero_page = 0; req_index = 6'd3;
        req_valid = 1'b1; rsp_ready = 1'b0;
        @(negedge clk);
        held = expect_rsp(pg, 1, 0, 3);
        check_rsp("R8 R9 first", held);
        req_codes = {64{2'b11}}; req_index = 6'd10;
        check_eq("R9 req_ready stalled", 32'(req_ready), 32'd0);
        repeat (3) @(negedge clk);
        check_rsp("R9 held", held);
        check_eq("R9 req_ready still low", 32'(req_ready), 32'd0);
        // release: pending request replaces result on the same edge
        rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp("R8 replace", expect_rsp({64{2'b11}}, 1, 0, 10));
        @(negedge clk);
        check_eq("R8 drained", 32'(rsp_valid), 32'd0);

        // Random pages and indices
        for (int n = 0; n < 400; n++) begin
            logic [127:0] rc;
            bit c, z;
            int ix;
            rc = {$urandom(), $urandom(), $urandom(), $urandom()};
            c = ($urandom_range(0, 9) != 0);
            z = ($urandom_range(0, 19) == 0);
            ix = $urandom_range(0, 63);
            send("R1 R2 R6 random", rc, c, z, ix);
        end

        done = 1'b1;
        finish_up();
    end

endmodule